// File: doc/BRIEF.md
# I2C Command-Word Transaction Engine

This block carries out one whole I2C master transaction from a single 64-bit command word that a host writes. The word holds a go bit, an operation code that selects 7-bit or 10-bit target addressing with or without an internal register address, a direction bit, a byte count and up to four data bytes. A companion extension word supplies up to four more data bytes and, when asked for, the upper byte of a two-byte internal address. Once started, the engine produces the byte-level sequence START, address bytes, optional internal-address bytes, optional repeated START with a read header, then the data bytes and STOP.

The engine talks to a byte-level link that stands for the SCL/SDA shifter. For each step it raises `lnk_go` for one cycle together with an operation code and a byte, then waits for `lnk_done`. The link reports a target NAK on written bytes and returns the received byte on reads. When the transaction ends, the engine clears the go bit and writes back a success flag. On a read it also returns the data. On a failure it returns a status code instead. It then raises a completion flag in its interrupt register.

Top module: `i2ccw_engine`

## Requirements
- R1: Writing the command register (`host_sel`=0) with bit 63 set, while bit 63 reads 0, starts a transaction. Bit 63 reads 1 until the transaction ends and 0 afterwards. Bit 56 then reads 1 on success and 0 on failure.
- R2: The operation code in bits 60:57 takes these values: 0 is 7-bit addressing, 1 is 7-bit addressing with an internal address, 2 is 10-bit addressing, 3 is 10-bit addressing with an internal address. Any other value ends the transaction with no link activity, bit 56 at 0 and code 8'hFF in bits 7:0.
- R3: When bit 55 is set, the transaction moves (bits 54:52)+1 bytes. When bit 55 is clear, it moves exactly one byte.
- R4: Link operation codes are START=0, RSTART=1, WRITE=2, READ=3 and STOP=4. A 7-bit address (bits 46:40) is sent as {addr,rw}. A 10-bit address (bits 49:40) is sent as {5'b11110,addr[9:8],rw} followed by addr[7:0]. A read without an internal address sends the 7-bit read byte at once. A 10-bit read sends the two-byte write form, then RSTART, then {5'b11110,addr[9:8],1}.
- R5: Operation codes 1 and 3 send the internal-address byte from bits 39:32 after the address bytes. When bit 61 is also set, extension bits 39:32 are sent first, then command bits 39:32.
- R6: Write data for n bytes comes from the 64-bit value {ext[31:0],cmd[31:0]}. Byte k (k=0 is sent first) is taken from lane n-1-k. The transaction ends with STOP.
- R7: A read with an internal address sends the write prefix, then RSTART, then the read header, then the reads. The received bytes return in the same lane layout as R6, in cmd[31:0] and, when n>4, in ext[31:0]. Lanes above the count within a returned word read 0. The extension word is unchanged when n≤4.
- R8: The engine acknowledges every received byte except the last, which it NAKs (`lnk_mack`=0) before STOP.
- R9: A NAK on any written byte ends the transaction with STOP at once. The valid bit clears, bit 56 stays 0 and bits 7:0 return 8'h20 for an address byte or 8'h30 for an internal-address or data byte.
- R10: While bit 63 is set, writes to the command and extension registers are ignored.
- R11: The interrupt register (`host_sel`=2) has a completion flag in bit 0, which is set when a transaction ends and cleared by writing 1, and an enable in bit 4. `irq` is the flag ANDed with the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 command, 1 extension, 2 interrupt |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Selected register contents |
| irq | output | 1 | Completion interrupt |
| lnk_go | output | 1 | One-cycle request for a link operation |
| lnk_op | output | 3 | Link operation code |
| lnk_byte | output | 8 | Byte to send for WRITE |
| lnk_mack | output | 1 | Acknowledge to give on READ |
| lnk_done | input | 1 | Link operation finished |
| lnk_nak | input | 1 | Target NAK on the finished WRITE |
| lnk_rx | input | 8 | Byte received on READ |

## Verification
The hardest case to reach from the ports is a target NAK landing on one particular byte of the prefix. That byte may be the second 10-bit address byte, the upper internal-address byte or the read header after RSTART, and each needs its own code and must stop the sequence early. The bench link model takes a NAK position counted in written bytes. Random commands across all four operation codes, both directions and all sizes are paired with random NAK positions, so early ends hit every kind of prefix byte. Directed runs cover the unknown operation code and host writes that arrive while a transaction is running.

// File: rtl/i2ccw_pkg.sv
package i2ccw_pkg;
   typedef enum logic [2:0] {
      LK_START  = 3'd0,
      LK_RSTART = 3'd1,
      LK_WRITE  = 3'd2,
      LK_READ   = 3'd3,
      LK_STOP   = 3'd4
   } link_op_e;

   typedef enum logic [3:0] {
      SQ_IDLE, SQ_START, SQ_PRE, SQ_RSTART, SQ_RADDR,
      SQ_WDATA, SQ_RDATA, SQ_STOP, SQ_FIN
   } seq_st_e;

   localparam int VALID_BIT  = 63;
   localparam int EIA_BIT    = 61;
   localparam int OP_LSB     = 57;
   localparam int RD_BIT     = 56;
   localparam int SOVR_BIT   = 55;
   localparam int SIZE_LSB   = 52;
   localparam int TADDR_LSB  = 40;
   localparam int IA_LSB     = 32;
   localparam int INT_FLAG_BIT = 0;
   localparam int INT_EN_BIT   = 4;

   localparam logic [1:0] SEL_CMD = 2'd0;
   localparam logic [1:0] SEL_EXT = 2'd1;
   localparam logic [1:0] SEL_INT = 2'd2;

   localparam logic [4:0] HDR10         = 5'b11110;
   localparam logic [7:0] CODE_NONE     = 8'h00;
   localparam logic [7:0] CODE_ADDR_NAK = 8'h20;
   localparam logic [7:0] CODE_DATA_NAK = 8'h30;
   localparam logic [7:0] CODE_BAD_OP   = 8'hFF;

   typedef struct packed {
      logic        legal;
      logic        rd;
      logic [3:0]  nbytes;
      logic [2:0]  pcnt;
      logic [1:0]  alen;
      logic [31:0] pre;
      logic [7:0]  raddr;
   } plan_t;
endpackage

// File: rtl/i2ccw_decode.sv
module i2ccw_decode
   import i2ccw_pkg::*;
#(
   parameter bit ADDR10_EN = 1'b1
) (
   input  logic [3:0] op,
   input  logic       rd,
   input  logic       sovr,
   input  logic [2:0] size_m1,
   input  logic [9:0] taddr,
   input  logic       eia,
   input  logic [7:0] ia_lo,
   input  logic [7:0] ia_hi,
   output plan_t      plan
);
   logic       ten, ia, ten_ok;
   logic [7:0] hdr_w, hdr_r;

   assign ten = op[1];
   assign ia  = op[0];

   generate
      if (ADDR10_EN) begin : g_a10
         assign ten_ok = 1'b1;
         assign hdr_w  = ten ? {HDR10, taddr[9:8], 1'b0} : {taddr[6:0], 1'b0};
         assign hdr_r  = ten ? {HDR10, taddr[9:8], 1'b1} : {taddr[6:0], 1'b1};
      end else begin : g_a7
         assign ten_ok = 1'b0;
         assign hdr_w  = {taddr[6:0], 1'b0};
         assign hdr_r  = {taddr[6:0], 1'b1};
      end
   endgenerate

   always_comb begin
      logic [2:0] k;
      plan       = '0;
      k          = '0;
      plan.legal = (op[3:2] == 2'b00) && (ten_ok || !ten);
      plan.rd    = rd;
      plan.nbytes = sovr ? ({1'b0, size_m1} + 4'd1) : 4'd1;
      plan.alen  = ten ? 2'd2 : 2'd1;
      plan.raddr = hdr_r;
      if (!rd || ia || ten) begin
         plan.pre[7:0] = hdr_w;
         k = 3'd1;
         if (ten) begin
            plan.pre[15:8] = taddr[7:0];
            k = 3'd2;
         end
         if (ia) begin
            if (eia) begin
               plan.pre[{k[1:0], 3'b000} +: 8] = ia_hi;
               k = k + 3'd1;
            end
            plan.pre[{k[1:0], 3'b000} +: 8] = ia_lo;
            k = k + 3'd1;
         end
      end
      plan.pcnt = k;
   end
endmodule

// File: rtl/i2ccw_seq.sv
module i2ccw_seq
   import i2ccw_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  plan_t             plan,
   input  logic [DATA_W-1:0] wdata,
   input  logic              lnk_done,
   input  logic              lnk_nak,
   input  logic [7:0]        lnk_rx,
   output logic              lnk_go,
   output logic [2:0]        lnk_op,
   output logic [7:0]        lnk_byte,
   output logic              lnk_mack,
   output logic              fin,
   output logic              ok,
   output logic [7:0]        code,
   output logic [DATA_W-1:0] rdata
);
   seq_st_e    st;
   logic       waiting, failed;
   logic [1:0] idx;
   logic [3:0] rem;
   logic [2:0] lane;

   assign lane     = rem[2:0] - 3'd1;
   assign fin      = (st == SQ_FIN);
   assign ok       = !failed;
   assign lnk_mack = (rem != 4'd1);
   assign lnk_go   = !waiting && (st != SQ_IDLE) && (st != SQ_FIN);

   always_comb begin
      lnk_op   = LK_STOP;
      lnk_byte = '0;
      case (st)
         SQ_START:  lnk_op = LK_START;
         SQ_RSTART: lnk_op = LK_RSTART;
         SQ_PRE:    begin lnk_op = LK_WRITE; lnk_byte = plan.pre[{idx, 3'b000} +: 8]; end
         SQ_RADDR:  begin lnk_op = LK_WRITE; lnk_byte = plan.raddr; end
         SQ_WDATA:  begin lnk_op = LK_WRITE; lnk_byte = wdata[{lane, 3'b000} +: 8]; end
         SQ_RDATA:  lnk_op = LK_READ;
         default:   lnk_op = LK_STOP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= SQ_IDLE; waiting <= 1'b0; failed <= 1'b0;
         idx <= '0; rem <= '0; code <= CODE_NONE; rdata <= '0;
      end else if (st == SQ_IDLE) begin
         if (launch) begin
            failed <= !plan.legal;
            code   <= plan.legal ? CODE_NONE : CODE_BAD_OP;
            rdata  <= '0;
            idx    <= '0;
            rem    <= plan.nbytes;
            st     <= plan.legal ? SQ_START : SQ_FIN;
         end
      end else if (st == SQ_FIN) begin
         st <= SQ_IDLE;
      end else if (lnk_go) begin
         waiting <= 1'b1;
      end else if (waiting && lnk_done) begin
         waiting <= 1'b0;
         case (st)
            SQ_START: st <= (plan.pcnt != 3'd0) ? SQ_PRE : SQ_RADDR;
            SQ_PRE: begin
               if (lnk_nak) begin
                  failed <= 1'b1;
                  code   <= (idx < plan.alen) ? CODE_ADDR_NAK : CODE_DATA_NAK;
                  st     <= SQ_STOP;
               end else if ({1'b0, idx} == plan.pcnt - 3'd1) begin
                  st <= plan.rd ? SQ_RSTART : SQ_WDATA;
               end else begin
                  idx <= idx + 2'd1;
               end
            end
            SQ_RSTART: st <= SQ_RADDR;
            SQ_RADDR: begin
               if (lnk_nak) begin
                  failed <= 1'b1; code <= CODE_ADDR_NAK; st <= SQ_STOP;
               end else begin
                  st <= SQ_RDATA;
               end
            end
            SQ_WDATA: begin
               if (lnk_nak) begin
                  failed <= 1'b1; code <= CODE_DATA_NAK; st <= SQ_STOP;
               end else if (rem == 4'd1) st <= SQ_STOP;
               else rem <= rem - 4'd1;
            end
            SQ_RDATA: begin
               rdata <= {rdata[DATA_W-9:0], lnk_rx};
               if (rem == 4'd1) st <= SQ_STOP;
               else rem <= rem - 4'd1;
            end
            SQ_STOP: st <= SQ_FIN;
            default: st <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/i2ccw_engine.sv
module i2ccw_engine
   import i2ccw_pkg::*;
#(
   parameter bit ADDR10_EN = 1'b1,
   parameter int MAX_BYTES = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_wr,
   input  logic [1:0]  host_sel,
   input  logic [63:0] host_wdata,
   output logic [63:0] host_rdata,
   output logic        irq,
   output logic        lnk_go,
   output logic [2:0]  lnk_op,
   output logic [7:0]  lnk_byte,
   output logic        lnk_mack,
   input  logic        lnk_done,
   input  logic        lnk_nak,
   input  logic [7:0]  lnk_rx
);
   localparam int DATA_W = MAX_BYTES * 8;
   localparam int HALF_W = DATA_W / 2;

   generate
      if (MAX_BYTES != 8) begin : g_bad_bytes
         $error("command word format fixes MAX_BYTES at 8");
      end
   endgenerate

   logic [63:0]       cmd_q, ext_q;
   logic              launch, int_flag, int_en;
   logic              seq_fin, seq_ok;
   logic [7:0]        seq_code;
   logic [DATA_W-1:0] seq_rdata;
   plan_t             plan;
   logic              busy, wr_cmd, wr_ext;

   assign busy   = cmd_q[VALID_BIT];
   assign wr_cmd = host_wr && (host_sel == SEL_CMD) && !busy;
   assign wr_ext = host_wr && (host_sel == SEL_EXT) && !busy;
   assign irq    = int_flag && int_en;

   i2ccw_decode #(.ADDR10_EN(ADDR10_EN)) u_dec (
      .op(cmd_q[OP_LSB +: 4]), .rd(cmd_q[RD_BIT]), .sovr(cmd_q[SOVR_BIT]),
      .size_m1(cmd_q[SIZE_LSB +: 3]), .taddr(cmd_q[TADDR_LSB +: 10]),
      .eia(cmd_q[EIA_BIT]), .ia_lo(cmd_q[IA_LSB +: 8]), .ia_hi(ext_q[IA_LSB +: 8]),
      .plan(plan)
   );

   i2ccw_seq #(.DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .launch(launch), .plan(plan),
      .wdata({ext_q[HALF_W-1:0], cmd_q[HALF_W-1:0]}),
      .lnk_done(lnk_done), .lnk_nak(lnk_nak), .lnk_rx(lnk_rx),
      .lnk_go(lnk_go), .lnk_op(lnk_op), .lnk_byte(lnk_byte), .lnk_mack(lnk_mack),
      .fin(seq_fin), .ok(seq_ok), .code(seq_code), .rdata(seq_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0; ext_q <= '0; launch <= 1'b0;
         int_flag <= 1'b0; int_en <= 1'b0;
      end else begin
         launch <= wr_cmd && host_wdata[VALID_BIT];
         if (wr_cmd) cmd_q <= host_wdata;
         if (wr_ext) ext_q <= host_wdata;
         if (host_wr && host_sel == SEL_INT) begin
            int_en <= host_wdata[INT_EN_BIT];
            if (host_wdata[INT_FLAG_BIT]) int_flag <= 1'b0;
         end
         if (seq_fin) begin
            int_flag         <= 1'b1;
            cmd_q[VALID_BIT] <= 1'b0;
            cmd_q[RD_BIT]    <= seq_ok;
            if (!seq_ok) begin
               cmd_q[7:0] <= seq_code;
            end else if (plan.rd) begin
               cmd_q[HALF_W-1:0] <= seq_rdata[HALF_W-1:0];
               if (plan.nbytes > 4'd4) ext_q[HALF_W-1:0] <= seq_rdata[DATA_W-1:HALF_W];
            end
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      case (host_sel)
         SEL_CMD: host_rdata = cmd_q;
         SEL_EXT: host_rdata = ext_q;
         SEL_INT: begin
            host_rdata[INT_FLAG_BIT] = int_flag;
            host_rdata[INT_EN_BIT]   = int_en;
         end
         default: host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/i2ccw_chk.sv
module i2ccw_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [63:0] cmd_q,
   input logic [63:0] ext_q,
   input logic        fin,
   input logic        ok,
   input logic        flag,
   input logic        lnk_go
);
   AST_GO_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_go |-> cmd_q[63]); // R1
   AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !cmd_q[63]); // R1
   AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_go |=> !lnk_go); // R4
   AST_FAIL_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && !ok) |=> !cmd_q[56]); // R9
   AST_BUSY_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q[63] && !fin) |=> $stable(cmd_q)); // R10
   AST_BUSY_EXT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q[63] && !fin) |=> $stable(ext_q)); // R10
   AST_FLAG_ON_FIN: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> flag); // R11
endmodule

bind i2ccw_engine i2ccw_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_q(cmd_q), .ext_q(ext_q),
   .fin(seq_fin), .ok(seq_ok), .flag(int_flag), .lnk_go(lnk_go)
);

// File: tb/i2ccw_engine_tb.sv
`timescale 1ns/1ps
module i2ccw_engine_tb;
   import i2ccw_pkg::*;

   logic clk = 1'b0, rst_n = 1'b0;
   logic host_wr = 1'b0;
   logic [1:0] host_sel = 2'd0;
   logic [63:0] host_wdata = '0, host_rdata;
   logic irq, lnk_go, lnk_mack;
   logic [2:0] lnk_op;
   logic [7:0] lnk_byte;
   logic lnk_done = 1'b0, lnk_nak = 1'b0;
   logic [7:0] lnk_rx = '0;

   always #2.5 clk = ~clk;

   i2ccw_engine u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
      .lnk_go(lnk_go), .lnk_op(lnk_op), .lnk_byte(lnk_byte), .lnk_mack(lnk_mack),
      .lnk_done(lnk_done), .lnk_nak(lnk_nak), .lnk_rx(lnk_rx)
   );

   int nchk = 0, nbad = 0;
   int cycles = 0;

   // link model: records operations, answers two cycles later
   int lg_n, sw_i, sr_i, nak_at, cnt;
   logic [2:0] lg_op [32];
   logic [7:0] lg_b  [32];
   logic       lg_m  [32];
   logic       pnak;
   logic [7:0] prx;

   function automatic logic [7:0] rbyte(input int k);
      logic [7:0] kk;
      kk = 8'(k);
      return 8'hC3 ^ (kk * 8'd37);
   endfunction

   initial cnt = 0;
   always @(negedge clk) begin
      lnk_done = 1'b0;
      lnk_nak  = 1'b0;
      if (cnt > 0) begin
         if (cnt == 1) begin lnk_done = 1'b1; lnk_nak = pnak; lnk_rx = prx; end
         cnt = cnt - 1;
      end
      if (lnk_go) begin
         if (lg_n < 32) begin
            lg_op[lg_n] = lnk_op;
            lg_b[lg_n]  = (lnk_op == LK_WRITE) ? lnk_byte : 8'h00;
            lg_m[lg_n]  = (lnk_op == LK_READ) ? lnk_mack : 1'b0;
         end
         lg_n = lg_n + 1;
         pnak = 1'b0;
         prx  = 8'h00;
         if (lnk_op == LK_WRITE) begin
            pnak = (sw_i == nak_at);
            sw_i = sw_i + 1;
         end
         if (lnk_op == LK_READ) begin
            prx  = rbyte(sr_i);
            sr_i = sr_i + 1;
         end
         cnt = 2;
      end
   end

   // expected model
   int e_n, ew;
   logic [2:0] e_op [32];
   logic [7:0] e_b  [32];
   logic       e_m  [32];
   logic       dead;
   logic [7:0] e_code;

   task automatic epush(input logic [2:0] o, input logic [7:0] b, input logic m);
      e_op[e_n] = o; e_b[e_n] = b; e_m[e_n] = m; e_n = e_n + 1;
   endtask

   task automatic ewrite(input logic [7:0] b, input bit is_addr);
      if (!dead) begin
         epush(LK_WRITE, b, 1'b0);
         if (ew == nak_at) begin
            dead = 1'b1;
            e_code = is_addr ? 8'h20 : 8'h30;
         end
         ew = ew + 1;
      end
   endtask

   task automatic chk(input bit cond, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nchk = nchk + 1;
      if (!cond) begin
         nbad = nbad + 1;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic hw(input logic [1:0] sel, input logic [63:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_sel = sel; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_sel = SEL_CMD;
   endtask

   task automatic hr(input logic [1:0] sel, output logic [63:0] d);
      host_sel = sel;
      #1;
      d = host_rdata;
      host_sel = SEL_CMD;
   endtask

   logic int_en_tb = 1'b0;

   task automatic run(input logic [63:0] c, input logic [63:0] x, input int nk,
                      input string tag, input bit poke);
      logic [3:0] op;
      logic rd, ten, ia;
      int n;
      logic [9:0] a;
      logic [63:0] dv, dr, ecmd, eext, got;
      bit mism;
      op = c[60:57]; rd = c[56]; ten = op[1]; ia = op[0];
      n  = c[55] ? int'(c[54:52]) + 1 : 1;
      a  = c[49:40];
      dv = {x[31:0], c[31:0]};
      dr = '0;
      e_n = 0; ew = 0; dead = 1'b0; e_code = 8'h00;
      nak_at = nk;
      if (op > 4'd3) begin
         dead = 1'b1; e_code = 8'hFF;
      end else begin
         epush(LK_START, 8'h00, 1'b0);
         if (!rd || ia || ten) begin
            ewrite(ten ? {5'b11110, a[9:8], 1'b0} : {a[6:0], 1'b0}, 1'b1);
            if (ten) ewrite(a[7:0], 1'b1);
            if (ia) begin
               if (c[61]) ewrite(x[39:32], 1'b0);
               ewrite(c[39:32], 1'b0);
            end
            if (rd && !dead) epush(LK_RSTART, 8'h00, 1'b0);
         end
         if (rd) begin
            ewrite(ten ? {5'b11110, a[9:8], 1'b1} : {a[6:0], 1'b1}, 1'b1);
            for (int k = 0; k < n; k++)
               if (!dead) begin
                  epush(LK_READ, 8'h00, k != n - 1);
                  dr = {dr[55:0], rbyte(k)};
               end
         end else begin
            for (int k = 0; k < n; k++) ewrite(dv[8*(n-1-k) +: 8], 1'b0);
         end
         epush(LK_STOP, 8'h00, 1'b0);
      end
      ecmd = c; eext = x;
      ecmd[63] = 1'b0;
      ecmd[56] = !dead;
      if (dead) ecmd[7:0] = e_code;
      else if (rd) begin
         ecmd[31:0] = dr[31:0];
         if (n > 4) eext[31:0] = dr[63:32];
      end
      lg_n = 0; sw_i = 0; sr_i = 0;
      hw(SEL_EXT, x);
      hw(SEL_CMD, c);
      hr(SEL_CMD, got);
      chk(got[63] == 1'b1, "R1", "valid while busy", {63'd0, got[63]}, 64'd1);
      if (poke) begin
         hw(SEL_EXT, '1);
         hw(SEL_CMD, 64'h0);
      end
      do begin
         @(negedge clk);
         hr(SEL_CMD, got);
      end while (got[63]);
      repeat (2) @(negedge clk);
      mism = (lg_n != e_n);
      for (int i = 0; i < e_n && i < 32; i++)
         if (lg_op[i] !== e_op[i] || lg_b[i] !== e_b[i] || lg_m[i] !== e_m[i]) mism = 1'b1;
      chk(!mism, tag, "link sequence (count)", 64'(lg_n), 64'(e_n));
      hr(SEL_CMD, got);
      chk(got === ecmd, "R1 R9", "returned command word", got, ecmd);
      hr(SEL_EXT, got);
      chk(got === eext, "R7", "extension word", got, eext);
      hr(SEL_INT, got);
      chk(got[0] == 1'b1, "R11", "completion flag", got, 64'd1);
      hw(SEL_INT, int_en_tb ? 64'h11 : 64'h01);
   endtask

   function automatic logic [63:0] mk(input logic [3:0] op, input bit rd, input bit sovr,
      input logic [2:0] sz, input logic [9:0] a, input bit eia, input logic [7:0] ia,
      input logic [31:0] d);
      logic [63:0] c;
      c = '0;
      c[63] = 1'b1; c[61] = eia; c[60:57] = op; c[56] = rd; c[55] = sovr;
      c[54:52] = sz; c[49:40] = a; c[39:32] = ia; c[31:0] = d;
      return c;
   endfunction

   initial begin
      forever begin
         @(posedge clk);
         cycles = cycles + 1;
         if (cycles > 150000) begin
            nbad = nbad + 1; nchk = nchk + 1;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
         end
      end
   end

   initial begin
      logic [63:0] v;
      void'($urandom(32'd4711));
      lg_n = 0; sw_i = 0; sr_i = 0; nak_at = 99;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      hr(SEL_CMD, v);
      chk(v == 64'd0, "R1", "reset command word", v, 64'd0);
      hr(SEL_INT, v);
      chk(v == 64'd0 && irq == 1'b0, "R11", "reset interrupt", v, 64'd0);

      run(mk(4'd0, 0, 1, 3'd2, 10'h052, 0, 8'h00, 32'h00AABBCC), 64'h0, 99, "R6", 0);
      run(mk(4'd0, 1, 0, 3'd5, 10'h033, 0, 8'h00, 32'h12345678), 64'h0, 99, "R3", 0);
      run(mk(4'd0, 1, 1, 3'd2, 10'h021, 0, 8'h00, 32'h0), 64'hFFFF_FFFF, 99, "R8", 0);
      run(mk(4'd1, 1, 1, 3'd5, 10'h050, 1, 8'h34, 32'h0), 64'h0000_0012_DEAD_BEEF, 99, "R5", 0);
      run(mk(4'd2, 0, 1, 3'd7, 10'h2A5, 0, 8'h00, 32'h55667788), 64'h0000_0000_11223344, 99, "R4", 0);
      run(mk(4'd3, 1, 1, 3'd1, 10'h1F0, 0, 8'h9C, 32'h0), 64'h0, 99, "R7", 0);
      run(mk(4'd3, 1, 1, 3'd3, 10'h155, 1, 8'h01, 32'h0), 64'h0000_0077_0000_0000, 4, "R9", 0);
      run(mk(4'd0, 0, 1, 3'd3, 10'h011, 0, 8'h00, 32'h01020304), 64'h0, 0, "R9", 0);
      run(mk(4'd1, 0, 1, 3'd1, 10'h011, 0, 8'h40, 32'h0000A1A2), 64'h0, 2, "R9", 0);
      run(mk(4'd6, 0, 1, 3'd3, 10'h011, 0, 8'h00, 32'h01020304), 64'h0, 99, "R2", 0);
      run(mk(4'd1, 0, 1, 3'd4, 10'h03C, 0, 8'h10, 32'hCAFEF00D), 64'h0000_0000_00000042, 99, "R10", 1);

      int_en_tb = 1'b1;
      hw(SEL_INT, 64'h10);
      run(mk(4'd0, 0, 0, 3'd0, 10'h008, 0, 8'h00, 32'h000000E7), 64'h0, 99, "R6", 0);
      hw(SEL_INT, 64'h10);
      run(mk(4'd0, 0, 0, 3'd0, 10'h008, 0, 8'h00, 32'h00000011), 64'h0, 99, "R6", 0);
      hr(SEL_INT, v);
      chk(v[0] == 1'b0 && irq == 1'b0, "R11", "flag cleared by write of 1", v, 64'h10);
      hw(SEL_INT, 64'h10);
      hr(SEL_INT, v);
      chk(v == 64'h10, "R11", "enable readback", v, 64'h10);
      hw(SEL_EXT, 64'h0);
      hw(SEL_CMD, mk(4'd0, 0, 0, 3'd0, 10'h009, 0, 8'h00, 32'h5));
      do begin @(negedge clk); hr(SEL_CMD, v); end while (v[63]);
      @(negedge clk);
      chk(irq == 1'b1, "R11", "irq with enable", {63'd0, irq}, 64'd1);
      hw(SEL_INT, 64'h11);
      chk(irq == 1'b0, "R11", "irq after clear", {63'd0, irq}, 64'd0);
      int_en_tb = 1'b0;
      hw(SEL_INT, 64'h00);

      for (int t = 0; t < 40; t++) begin
         logic [63:0] c, x;
         c = mk(4'($urandom % 4), 1'($urandom), 1'($urandom), 3'($urandom),
                10'($urandom), 1'($urandom), 8'($urandom), $urandom);
         x = {$urandom, $urandom};
         run(c, x, int'($urandom % 14), "R6", 0);
      end

      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule